// File: doc/BRIEF.md
# Microoperation Field Decoder and Register Datapath

This block carries out the register-transfer part of a microprogrammed control unit. Each clock it takes one microinstruction's three 3-bit microoperation fields (`f1_i`, `f2_i`, `f3_i`) and decodes them. It then applies the selected transfers to a 16-bit accumulator, a 16-bit data register, an 11-bit address register and an 11-bit program counter. It also drives the read and write port of a word-addressed data memory. All three fields act together, and every result is computed from the register values held before the clock edge.

A separate sequencer chooses the next microinstruction. To make its branch decisions, it reads three status outputs: the accumulator sign, an accumulator-is-zero flag, and the indirect bit of the data register. An instruction word held in the data register has the indirect flag in its top bit, the opcode below it, and the 11-bit operand address in bits 10:0.

Top module: `ucode_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator, data register, address register and program counter to zero on the next rising edge.
- R2: On `f1_i`, the code 001 adds DR to AC, 010 clears AC, 011 increments AC and 100 copies DR into AC. Arithmetic wraps modulo 2^16.
- R3: On `f1_i`, the code 101 loads AR from DR[10:0] and 110 loads AR from PC.
- R4: The `f1_i` code 111 writes DR into memory word AR at the edge. The `f2_i` code 100 loads DR with memory word AR as read before that edge, so a read and a write in the same cycle return the old word.
- R5: On `f2_i`, the code 001 subtracts DR from AC (modulo 2^16), 010 ORs DR into AC and 011 ANDs DR into AC.
- R6: On `f2_i`, the code 101 copies AC into DR, 110 increments DR and 111 replaces DR[10:0] with PC while DR[15:11] keep their value.
- R7: On `f3_i`, the code 001 XORs DR into AC and 010 complements AC. The code 011 shifts AC left and 100 shifts AC right, and both shifts bring in a 0 bit.
- R8: On `f3_i`, the code 101 increments PC (modulo 2^11), 110 copies AR into PC, and 111 changes nothing.
- R9: All three fields act on the same edge, and each uses the register values from before that edge. For example, AR<=PC together with PC<=PC+1 leaves the old PC in AR.
- R10: When more than one field targets AC, the `f3_i` operation takes effect. If `f3_i` does not target AC, the `f2_i` operation takes effect over the `f1_i` one.
- R11: `ac_neg_o` equals AC bit 15, `ac_zero_o` is 1 exactly when AC is zero, and `dr_ind_o` equals DR bit 15.
- R12: A register that no field targets in a cycle keeps its value, and code 000 in any field does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f1_i | input | 3 | First microoperation field |
| f2_i | input | 3 | Second microoperation field |
| f3_i | input | 3 | Third microoperation field |
| ac_o | output | 16 | Accumulator |
| dr_o | output | 16 | Data register |
| ar_o | output | 11 | Address register |
| pc_o | output | 11 | Program counter |
| ac_neg_o | output | 1 | Accumulator sign bit |
| ac_zero_o | output | 1 | Accumulator equals zero |
| dr_ind_o | output | 1 | Indirect bit (DR bit 15) |

## Verification
Each field combination presented in a cycle becomes visible on all four register outputs, and on the three flags, one rising edge later; no result takes longer. A memory write becomes visible only through a later read into DR, which is itself due one edge after that read is issued. The driver records the target cycle of each expected item, and the monitor compares items only at the falling edge of that cycle, so every check samples the registers that the single intervening edge has just committed.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

  typedef enum logic [3:0] {
    ACS_HOLD, ACS_ADD, ACS_SUB, ACS_CLR, ACS_INC, ACS_DR, ACS_OR, ACS_AND,
    ACS_XOR, ACS_CPL, ACS_SHL, ACS_SHR
  } ac_sel_e;

  typedef enum logic [2:0] {
    DRS_HOLD, DRS_MEM, DRS_AC, DRS_INC, DRS_PC
  } dr_sel_e;

  typedef enum logic [1:0] {
    ARS_HOLD, ARS_DR, ARS_PC
  } ar_sel_e;

  typedef enum logic [1:0] {
    PCS_HOLD, PCS_INC, PCS_AR
  } pc_sel_e;

  typedef struct packed {
    ac_sel_e ac;
    dr_sel_e dr;
    ar_sel_e ar;
    pc_sel_e pc;
    logic    mem_we;
  } ctl_t;

endpackage

// File: rtl/mdp_decode.sv
module mdp_decode
  import mdp_pkg::*;
(
  input  logic [2:0] f1,
  input  logic [2:0] f2,
  input  logic [2:0] f3,
  output ctl_t       ctl
);

  // AC has writers in all three fields; later fields override earlier ones.
  always_comb begin
    ctl.ac = ACS_HOLD;
    case (f1)
      3'b001:  ctl.ac = ACS_ADD;
      3'b010:  ctl.ac = ACS_CLR;
      3'b011:  ctl.ac = ACS_INC;
      3'b100:  ctl.ac = ACS_DR;
      default: ;
    endcase
    case (f2)
      3'b001:  ctl.ac = ACS_SUB;
      3'b010:  ctl.ac = ACS_OR;
      3'b011:  ctl.ac = ACS_AND;
      default: ;
    endcase
    case (f3)
      3'b001:  ctl.ac = ACS_XOR;
      3'b010:  ctl.ac = ACS_CPL;
      3'b011:  ctl.ac = ACS_SHL;
      3'b100:  ctl.ac = ACS_SHR;
      default: ;
    endcase
  end

  always_comb begin
    case (f2)
      3'b100:  ctl.dr = DRS_MEM;
      3'b101:  ctl.dr = DRS_AC;
      3'b110:  ctl.dr = DRS_INC;
      3'b111:  ctl.dr = DRS_PC;
      default: ctl.dr = DRS_HOLD;
    endcase
  end

  always_comb begin
    case (f1)
      3'b101:  ctl.ar = ARS_DR;
      3'b110:  ctl.ar = ARS_PC;
      default: ctl.ar = ARS_HOLD;
    endcase
  end

  always_comb begin
    case (f3)
      3'b101:  ctl.pc = PCS_INC;
      3'b110:  ctl.pc = PCS_AR;
      default: ctl.pc = PCS_HOLD;
    endcase
  end

  assign ctl.mem_we = (f1 == 3'b111);

endmodule

// File: rtl/mdp_alu.sv
module mdp_alu
  import mdp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] ac,
  input  logic [DATA_W-1:0] dr,
  input  ac_sel_e           sel,
  output logic [DATA_W-1:0] ac_nxt
);

  always_comb begin
    case (sel)
      ACS_ADD: ac_nxt = ac + dr;
      ACS_SUB: ac_nxt = ac - dr;
      ACS_CLR: ac_nxt = '0;
      ACS_INC: ac_nxt = ac + DATA_W'(1);
      ACS_DR:  ac_nxt = dr;
      ACS_OR:  ac_nxt = ac | dr;
      ACS_AND: ac_nxt = ac & dr;
      ACS_XOR: ac_nxt = ac ^ dr;
      ACS_CPL: ac_nxt = ~ac;
      ACS_SHL: ac_nxt = {ac[DATA_W-2:0], 1'b0};
      ACS_SHR: ac_nxt = {1'b0, ac[DATA_W-1:1]};
      default: ac_nxt = ac;
    endcase
  end

endmodule

// File: rtl/mdp_mem.sv
module mdp_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Asynchronous read: the word reaches DR within the same microcycle.
  assign rdata = mem[addr];

endmodule

// File: rtl/ucode_datapath.sv
module ucode_datapath
  import mdp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        f1_i,
  input  logic [2:0]        f2_i,
  input  logic [2:0]        f3_i,
  output logic [DATA_W-1:0] ac_o,
  output logic [DATA_W-1:0] dr_o,
  output logic [ADDR_W-1:0] ar_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              ac_neg_o,
  output logic              ac_zero_o,
  output logic              dr_ind_o
);

  localparam int TOP = DATA_W - 1;

  ctl_t              ctl;
  logic [DATA_W-1:0] ac_q, dr_q, ac_nxt, dr_nxt, mem_rd;
  logic [ADDR_W-1:0] ar_q, pc_q, ar_nxt, pc_nxt;

  mdp_decode u_dec (
    .f1  (f1_i),
    .f2  (f2_i),
    .f3  (f3_i),
    .ctl (ctl)
  );

  mdp_alu #(.DATA_W(DATA_W)) u_alu (
    .ac     (ac_q),
    .dr     (dr_q),
    .sel    (ctl.ac),
    .ac_nxt (ac_nxt)
  );

  mdp_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (ctl.mem_we),
    .addr  (ar_q),
    .wdata (dr_q),
    .rdata (mem_rd)
  );

  always_comb begin
    case (ctl.dr)
      DRS_MEM: dr_nxt = mem_rd;
      DRS_AC:  dr_nxt = ac_q;
      DRS_INC: dr_nxt = dr_q + DATA_W'(1);
      DRS_PC:  dr_nxt = {dr_q[TOP:ADDR_W], pc_q};
      default: dr_nxt = dr_q;
    endcase
  end

  always_comb begin
    case (ctl.ar)
      ARS_DR:  ar_nxt = dr_q[ADDR_W-1:0];
      ARS_PC:  ar_nxt = pc_q;
      default: ar_nxt = ar_q;
    endcase
  end

  always_comb begin
    case (ctl.pc)
      PCS_INC: pc_nxt = pc_q + ADDR_W'(1);
      PCS_AR:  pc_nxt = ar_q;
      default: pc_nxt = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_q <= '0;
      dr_q <= '0;
      ar_q <= '0;
      pc_q <= '0;
    end else begin
      ac_q <= ac_nxt;
      dr_q <= dr_nxt;
      ar_q <= ar_nxt;
      pc_q <= pc_nxt;
    end
  end

  assign ac_o      = ac_q;
  assign dr_o      = dr_q;
  assign ar_o      = ar_q;
  assign pc_o      = pc_q;
  assign ac_neg_o  = ac_q[TOP];
  assign ac_zero_o = (ac_q == '0);
  assign dr_ind_o  = dr_q[TOP];

endmodule

// File: rtl/mdp_checker.sv
module mdp_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        f1_i,
  input logic [2:0]        f2_i,
  input logic [2:0]        f3_i,
  input logic [DATA_W-1:0] ac_o,
  input logic [DATA_W-1:0] dr_o,
  input logic [ADDR_W-1:0] ar_o,
  input logic [ADDR_W-1:0] pc_o
);

  logic f2_hits_ac, f3_hits_ac;
  assign f2_hits_ac = (f2_i == 3'b001) || (f2_i == 3'b010) || (f2_i == 3'b011);
  assign f3_hits_ac = (f3_i != 3'b000) && (f3_i <= 3'b100);

  // R2: clear from the first field when no later field touches AC
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    (f1_i == 3'b010 && !f2_hits_ac && !f3_hits_ac) |=> (ac_o == '0));

  // R3: AR takes the PC value from before the edge
  a_r3_ar_from_pc: assert property (@(posedge clk) disable iff (rst)
    (f1_i == 3'b110) |=> (ar_o == $past(pc_o)));

  // R6: DR takes the AC value from before the edge
  a_r6_dr_from_ac: assert property (@(posedge clk) disable iff (rst)
    (f2_i == 3'b101) |=> (dr_o == $past(ac_o)));

  // R8: PC increments by one
  a_r8_pc_inc: assert property (@(posedge clk) disable iff (rst)
    (f3_i == 3'b101) |=> (pc_o == ADDR_W'($past(pc_o) + ADDR_W'(1))));

  // R10: XOR from the third field wins whatever the others select
  a_r10_f3_wins: assert property (@(posedge clk) disable iff (rst)
    (f3_i == 3'b001) |=> (ac_o == ($past(ac_o) ^ $past(dr_o))));

  // R12: PC holds when the third field does not address it
  a_r12_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (f3_i != 3'b101 && f3_i != 3'b110) |=> $stable(pc_o));

  // R12: AR holds when the first field does not address it
  a_r12_ar_hold: assert property (@(posedge clk) disable iff (rst)
    (f1_i != 3'b101 && f1_i != 3'b110) |=> $stable(ar_o));

endmodule

bind ucode_datapath mdp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .f1_i (f1_i),
  .f2_i (f2_i),
  .f3_i (f3_i),
  .ac_o (ac_o),
  .dr_o (dr_o),
  .ar_o (ar_o),
  .pc_o (pc_o)
);

// File: tb/ucode_datapath_tb.sv
module ucode_datapath_tb;

  typedef struct {
    string       tag;
    int          due;
    logic [15:0] ac;
    logic [15:0] dr;
    logic [10:0] ar;
    logic [10:0] pc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  f1 = '0, f2 = '0, f3 = '0;
  logic [15:0] ac_o, dr_o;
  logic [10:0] ar_o, pc_o;
  logic        ac_neg_o, ac_zero_o, dr_ind_o;

  exp_t        sb[$];
  int          cycle = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  logic [15:0] m_ac = '0, m_dr = '0;
  logic [10:0] m_ar = '0, m_pc = '0;
  logic [15:0] m_mem [2048];

  always #2 clk = ~clk;   // 250 MHz

  ucode_datapath u_dut (
    .clk       (clk),
    .rst       (rst),
    .f1_i      (f1),
    .f2_i      (f2),
    .f3_i      (f3),
    .ac_o      (ac_o),
    .dr_o      (dr_o),
    .ar_o      (ar_o),
    .pc_o      (pc_o),
    .ac_neg_o  (ac_neg_o),
    .ac_zero_o (ac_zero_o),
    .dr_ind_o  (dr_ind_o)
  );

  always @(posedge clk) cycle <= cycle + 1;

  // Monitor: compare each expected item in the falling edge of its due cycle.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cycle) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (ac_o !== e.ac || dr_o !== e.dr || ar_o !== e.ar || pc_o !== e.pc ||
          ac_neg_o !== e.ac[15] || ac_zero_o !== (e.ac == 16'h0) ||
          dr_ind_o !== e.dr[15]) begin
        fails++;
        $display("FAIL %s: got ac=%h dr=%h ar=%h pc=%h n=%b z=%b i=%b exp ac=%h dr=%h ar=%h pc=%h n=%b z=%b i=%b",
                 e.tag, ac_o, dr_o, ar_o, pc_o, ac_neg_o, ac_zero_o, dr_ind_o,
                 e.ac, e.dr, e.ar, e.pc, e.ac[15], (e.ac == 16'h0), e.dr[15]);
      end
    end
  end

  // Driver: apply one microinstruction, advance the reference model, queue the result.
  task automatic step(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c,
                      input string tag);
    logic [15:0] n_ac, n_dr;
    logic [10:0] n_ar, n_pc;
    exp_t e;
    @(posedge clk);
    #1;
    f1 = a; f2 = b; f3 = c;
    n_ac = m_ac; n_dr = m_dr; n_ar = m_ar; n_pc = m_pc;
    case (a)
      3'd1: n_ac = m_ac + m_dr;
      3'd2: n_ac = 16'h0;
      3'd3: n_ac = m_ac + 16'd1;
      3'd4: n_ac = m_dr;
      3'd5: n_ar = m_dr[10:0];
      3'd6: n_ar = m_pc;
      default: ;
    endcase
    case (b)
      3'd1: n_ac = m_ac - m_dr;
      3'd2: n_ac = m_ac | m_dr;
      3'd3: n_ac = m_ac & m_dr;
      3'd4: n_dr = m_mem[m_ar];
      3'd5: n_dr = m_ac;
      3'd6: n_dr = m_dr + 16'd1;
      3'd7: n_dr = {m_dr[15:11], m_pc};
      default: ;
    endcase
    case (c)
      3'd1: n_ac = m_ac ^ m_dr;
      3'd2: n_ac = ~m_ac;
      3'd3: n_ac = {m_ac[14:0], 1'b0};
      3'd4: n_ac = {1'b0, m_ac[15:1]};
      3'd5: n_pc = m_pc + 11'd1;
      3'd6: n_pc = m_ar;
      default: ;
    endcase
    if (a == 3'd7) m_mem[m_ar] = m_dr;
    m_ac = n_ac; m_dr = n_dr; m_ar = n_ar; m_pc = n_pc;
    e.tag = tag; e.due = cycle + 1;
    e.ac = m_ac; e.dr = m_dr; e.ar = m_ar; e.pc = m_pc;
    sb.push_back(e);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) m_mem[i] = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    step(0, 0, 0, "R1 reset state");
    step(3, 0, 0, "R2 inc AC");
    step(3, 0, 0, "R2 inc AC again");
    step(3, 0, 0, "R2 inc AC third");
    step(0, 5, 0, "R6 DR from AC");
    step(1, 0, 0, "R2 add DR");
    step(0, 6, 0, "R6 inc DR");
    step(0, 1, 0, "R5 sub DR");
    step(0, 2, 0, "R5 or DR");
    step(0, 3, 0, "R5 and DR");
    step(2, 0, 0, "R2 R11 clear AC zero flag");
    step(0, 1, 0, "R5 R11 sub wraps negative");
    step(0, 0, 4, "R7 shr inserts 0");
    step(0, 0, 3, "R7 shl inserts 0");
    step(0, 0, 3, "R7 shl drops top bit");
    step(0, 0, 2, "R7 complement");
    step(0, 0, 1, "R7 xor DR");
    step(4, 0, 0, "R2 AC from DR");
    step(0, 0, 0, "R12 nop holds all");
    step(0, 0, 5, "R8 inc PC");
    step(0, 0, 5, "R8 inc PC again");
    step(2, 0, 2, "R10 complement beats clear");
    step(0, 5, 0, "R6 R11 DR from AC sets indirect");
    step(0, 7, 0, "R6 DR low bits from PC");
    step(5, 0, 0, "R3 AR from DR");
    step(0, 0, 7, "R8 reserved code no effect");
    step(6, 0, 5, "R9 R3 AR old PC while PC incs");
    step(0, 0, 6, "R8 PC from AR");
    // PC wrap: build 0x7FF in AR then PC
    step(2, 0, 0, "R2 clear AC");
    step(0, 0, 2, "R7 complement to all ones");
    step(0, 5, 0, "R6 DR all ones");
    step(5, 0, 0, "R3 AR from DR top address");
    step(0, 0, 6, "R8 PC top address");
    step(0, 0, 5, "R8 PC wraps");
    // Memory
    step(2, 0, 0, "R2 clear AC for address");
    step(3, 0, 0, "R2 AC one");
    step(3, 0, 0, "R2 AC two");
    step(0, 5, 0, "R6 DR two");
    step(5, 0, 0, "R3 AR two");
    step(0, 0, 3, "R7 AC four");
    step(0, 5, 0, "R6 DR four");
    step(7, 0, 0, "R4 write four to word two");
    step(0, 6, 0, "R6 DR five");
    step(7, 4, 0, "R4 R9 write and read same word old data");
    step(0, 4, 0, "R4 read back new word");
    step(0, 4, 5, "R9 read with PC inc");
    // AC priority
    step(1, 1, 1, "R10 F3 xor beats F1 F2");
    step(3, 3, 0, "R10 F2 and beats F1 inc");
    step(4, 2, 0, "R10 F2 or beats F1 load");
    step(1, 2, 4, "R10 R9 shr beats both");
    step(0, 0, 0, "R12 final hold");
    repeat (3) @(posedge clk);
    #1 rst = 1'b1;
    m_ac = '0; m_dr = '0; m_ar = '0; m_pc = '0;
    @(posedge clk);
    begin
      exp_t e;
      e.tag = "R1 reset mid run"; e.due = cycle + 1;
      e.ac = '0; e.dr = '0; e.ar = '0; e.pc = '0;
      sb.push_back(e);
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule